// File: doc/BRIEF.md
# Flash Write/Erase Unlock Controller

This block sits between a processor's external-data write port and an on-chip flash array. Every external-data store passes through it. Depending on a small control register, a two-write key register and the target address, each store becomes one of four things: a data-RAM write, a flash byte-program command, a flash page-erase command, or nothing at all.

A program or erase command is issued only after the key register has received its two unlock bytes in the right order. The unlock is spent by that single operation. A bad key sequence, or a flash store made without a valid unlock, kills the key logic until reset. After each command the controller holds a busy flag for the program or erase time, counted in clocks. It then raises a one-cycle done pulse.

A debug-access gate separately grants or refuses debug read requests. The decision depends on the security byte held at the last user address of the flash.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the following outputs are all 0: `busy`, `done`, `key_locked`, `wr_en_bit`, `er_en_bit`, `ram_we`, `fl_prog` and `fl_erase`.
- R2: A control write (`reg_we`=1, `reg_sel`=0) loads the write-enable bit from data bit 0 and the erase-enable bit from data bit 1. The new values are visible on `wr_en_bit`/`er_en_bit` one cycle later.
- R3: While the write-enable bit is 0, an external-data store produces a one-cycle `ram_we` pulse one cycle later, carrying the store's address and data. No flash command is issued and the key state is left unchanged.
- R4: Key writes use `reg_we`=1 and `reg_sel`=1. Writing 0xA5 and then 0xF1 arms the unlock. With write-enable=1 and erase-enable=0, the next store below address 0x1E00 yields a one-cycle `fl_prog` pulse one cycle later, carrying the store's address and data.
- R5: When the unlock is armed and both enable bits are 1, a store below 0x1E00 yields a one-cycle `fl_erase` pulse. Its `fl_addr` is the page base, meaning the store address with its low 9 bits cleared (512-byte pages).
- R6: An unlock covers exactly one operation. A flash store (write-enable=1) made while not armed issues no command and sets `key_locked`.
- R7: Any key write other than 0xA5 in the idle state, or other than 0xF1 after 0xA5, sets `key_locked`. This includes any key write while armed. `key_locked` stays set until reset, and later key sequences can no longer arm a command.
- R8: An armed store to an address of 0x1E00 or above issues no command. It consumes the unlock but does not set `key_locked`.
- R9: `busy` rises together with a command pulse. It stays high for PROG_CYC cycles after a program and ERASE_CYC cycles after an erase. `done` pulses for one cycle in the cycle after `busy` falls.
- R10: While `busy` is high, control writes, key writes and stores are ignored. The enable bits and key state do not change, and no `ram_we` or command pulse is issued.
- R11: One cycle after `dbg_req`, `dbg_grant` is 1 if `sec_byte` is 0xFF. Otherwise `dbg_deny` is 1. Both outputs are 0 when no request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register, 1 selects key register |
| reg_wdata | input | DW | Register write data |
| xd_we | input | 1 | External-data store strobe |
| xd_addr | input | AW | Store address |
| xd_wdata | input | DW | Store data |
| sec_byte | input | DW | Current content of the security byte in flash |
| dbg_req | input | 1 | Debug read request |
| wr_en_bit | output | 1 | Flash write-enable bit |
| er_en_bit | output | 1 | Flash erase-enable bit |
| key_locked | output | 1 | Key logic dead until reset |
| busy | output | 1 | Flash operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ram_we | output | 1 | Data-RAM write pulse |
| ram_addr | output | AW | Data-RAM write address |
| ram_wdata | output | DW | Data-RAM write data |
| fl_prog | output | 1 | Flash byte-program command pulse |
| fl_erase | output | 1 | Flash page-erase command pulse |
| fl_addr | output | AW | Flash command address |
| fl_wdata | output | DW | Flash program data |
| dbg_grant | output | 1 | Debug access granted |
| dbg_deny | output | 1 | Debug access refused |

## Verification
Several properties are checked on every cycle:
- a command never targets the reserved region;
- an erase address is always page aligned;
- a command always matches the enable bits and starts busy;
- nothing is issued while busy;
- `done` follows every fall of busy;
- `key_locked` never clears without reset.

Other behaviour can only be shown by the bench's scenarios against a reference model and a flash stub. That covers the key ordering and one-shot consumption of the unlock, the exact busy lengths, the data-RAM redirection, and the debug gate responding to a security byte that was programmed and then erased.

// File: rtl/flu_pkg.sv
package flu_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2,
    KEY_DEAD  = 2'd3
  } key_st_e;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'hF1;
endpackage

// File: rtl/flu_key_fsm.sv
module flu_key_fsm
  import flu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_we,
  input  logic [DW-1:0] key_val,
  input  logic          consume,
  input  logic          violate,
  output key_st_e       st
);
  localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
  localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KEY_IDLE;
    end else if (st != KEY_DEAD) begin
      if (key_we) begin
        case (st)
          KEY_IDLE: st <= (key_val == K1) ? KEY_HALF  : KEY_DEAD;
          KEY_HALF: st <= (key_val == K2) ? KEY_ARMED : KEY_DEAD;
          default:  st <= KEY_DEAD;
        endcase
      end else if (violate) begin
        st <= KEY_DEAD;
      end else if (consume) begin
        st <= KEY_IDLE;
      end
    end
  end
endmodule

// File: rtl/flu_op_timer.sv
module flu_op_timer #(
  parameter int PROG_CYC  = 1500,
  parameter int ERASE_CYC = 375000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_erase,
  output logic busy,
  output logic done
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= is_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flu_dbg_gate.sv
module flu_dbg_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_req,
  input  logic [DW-1:0] sec_byte,
  output logic          dbg_grant,
  output logic          dbg_deny
);
  logic open_q;
  assign open_q = (sec_byte == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_grant <= 1'b0;
      dbg_deny  <= 1'b0;
    end else begin
      dbg_grant <= dbg_req && open_q;
      dbg_deny  <= dbg_req && !open_q;
    end
  end
endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
  import flu_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PAGE_W    = 9,
  parameter int RES_BASE  = 'h1E00,
  parameter int PROG_CYC  = 1500,
  parameter int ERASE_CYC = 375000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          xd_we,
  input  logic [AW-1:0] xd_addr,
  input  logic [DW-1:0] xd_wdata,
  input  logic [DW-1:0] sec_byte,
  input  logic          dbg_req,
  output logic          wr_en_bit,
  output logic          er_en_bit,
  output logic          key_locked,
  output logic          busy,
  output logic          done,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          fl_prog,
  output logic          fl_erase,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          dbg_grant,
  output logic          dbg_deny
);
  localparam logic [AW-1:0] RES_ADDR = AW'(RES_BASE);

  key_st_e kst;
  logic    take, ctrl_we, key_we, st_we;
  logic    armed, in_res, go_flash, consume, violate;

  // Nothing is accepted while an operation runs.
  assign take     = !busy;
  assign ctrl_we  = take && reg_we && !reg_sel;
  assign key_we   = take && reg_we &&  reg_sel;
  assign st_we    = take && xd_we;
  assign armed    = (kst == KEY_ARMED);
  assign in_res   = (xd_addr >= RES_ADDR);
  assign consume  = st_we && wr_en_bit && armed;
  assign violate  = st_we && wr_en_bit && !armed;
  assign go_flash = consume && !in_res;

  flu_key_fsm #(.DW(DW)) u_key (
    .clk(clk), .rst(rst), .key_we(key_we), .key_val(reg_wdata),
    .consume(consume), .violate(violate), .st(kst)
  );

  flu_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .start(go_flash), .is_erase(er_en_bit),
    .busy(busy), .done(done)
  );

  flu_dbg_gate #(.DW(DW)) u_dbg (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .sec_byte(sec_byte),
    .dbg_grant(dbg_grant), .dbg_deny(dbg_deny)
  );

  assign key_locked = (kst == KEY_DEAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_bit <= 1'b0;
      er_en_bit <= 1'b0;
    end else if (ctrl_we) begin
      wr_en_bit <= reg_wdata[0];
      er_en_bit <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      fl_prog   <= 1'b0;
      fl_erase  <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
    end else begin
      ram_we   <= st_we && !wr_en_bit;
      fl_prog  <= go_flash && !er_en_bit;
      fl_erase <= go_flash &&  er_en_bit;
      if (st_we && !wr_en_bit) begin
        ram_addr  <= xd_addr;
        ram_wdata <= xd_wdata;
      end
      if (go_flash) begin
        fl_addr  <= er_en_bit ? {xd_addr[AW-1:PAGE_W], PAGE_W'(0)} : xd_addr;
        fl_wdata <= xd_wdata;
      end
    end
  end
endmodule

// File: rtl/flash_unlock_ctrl_chk.sv
module flash_unlock_ctrl_chk #(
  parameter int AW       = 13,
  parameter int PAGE_W   = 9,
  parameter int RES_BASE = 'h1E00
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_bit,
  input logic          er_en_bit,
  input logic          key_locked,
  input logic          busy,
  input logic          done,
  input logic          ram_we,
  input logic          fl_prog,
  input logic          fl_erase,
  input logic [AW-1:0] fl_addr
);
  localparam logic [AW-1:0] RES_ADDR = AW'(RES_BASE);

  // R8
  cmd_outside_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_prog || fl_erase) |-> (fl_addr < RES_ADDR));

  // R5
  erase_page_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    fl_erase |-> (fl_addr[PAGE_W-1:0] == '0));

  // R5
  erase_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    fl_erase |-> (wr_en_bit && er_en_bit));

  // R4
  prog_needs_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    fl_prog |-> (wr_en_bit && !er_en_bit));

  // R9
  cmd_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_prog || fl_erase) |-> busy);

  // R10
  quiet_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(fl_prog || fl_erase || ram_we));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    key_locked |=> key_locked);
endmodule

bind flash_unlock_ctrl flash_unlock_ctrl_chk #(
  .AW(AW), .PAGE_W(PAGE_W), .RES_BASE(RES_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_bit(wr_en_bit), .er_en_bit(er_en_bit),
  .key_locked(key_locked), .busy(busy), .done(done), .ram_we(ram_we),
  .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_addr(fl_addr)
);

// File: tb/test_flash_unlock_ctrl.sv
module test_flash_unlock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13, DW = 8, PW = 9, RES = 'h1E00;
  localparam int PC = 5, EC = 20;
  localparam int SEC_ADDR = RES - 1;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_sel = 0, xd_we = 0, dbg_req = 0;
  logic [DW-1:0] reg_wdata = 0, xd_wdata = 0, sec_byte = 8'hFF;
  logic [AW-1:0] xd_addr = 0;
  logic wr_en_bit, er_en_bit, key_locked, busy, done, ram_we, fl_prog, fl_erase;
  logic dbg_grant, dbg_deny;
  logic [AW-1:0] ram_addr, fl_addr;
  logic [DW-1:0] ram_wdata, fl_wdata;

  int checks = 0, errors = 0, cyc = 0;
  // model
  bit m_wr, m_er;
  int m_k;  // 0 idle, 1 half, 2 armed, 3 dead
  logic [7:0] fmem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_unlock_ctrl #(.AW(AW), .DW(DW), .PAGE_W(PW), .RES_BASE(RES),
    .PROG_CYC(PC), .ERASE_CYC(EC)) i_flash_unlock_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .xd_we(xd_we), .xd_addr(xd_addr), .xd_wdata(xd_wdata), .sec_byte(sec_byte),
    .dbg_req(dbg_req), .wr_en_bit(wr_en_bit), .er_en_bit(er_en_bit),
    .key_locked(key_locked), .busy(busy), .done(done), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .fl_prog(fl_prog),
    .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .dbg_grant(dbg_grant), .dbg_deny(dbg_deny));

  function automatic logic [7:0] rd(int a);
    return fmem.exists(a) ? fmem[a] : 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk);
    @(negedge clk) rst = 0;
    m_wr = 0; m_er = 0; m_k = 0;
    @(negedge clk);
    chk({busy, done, key_locked, wr_en_bit, er_en_bit, ram_we, fl_prog, fl_erase} == 8'h0,
        "R1", {busy, done, key_locked, wr_en_bit, er_en_bit, ram_we, fl_prog, fl_erase}, 0);
  endtask

  task automatic ctrl_w(logic [7:0] v);
    @(negedge clk) begin reg_we = 1; reg_sel = 0; reg_wdata = v; end
    @(negedge clk) reg_we = 0;
    m_wr = v[0]; m_er = v[1];
    chk(wr_en_bit === m_wr && er_en_bit === m_er, "R2", {er_en_bit, wr_en_bit}, {m_er, m_wr});
  endtask

  task automatic key_w(logic [7:0] v);
    @(negedge clk) begin reg_we = 1; reg_sel = 1; reg_wdata = v; end
    @(negedge clk) reg_we = 0;
    if (m_k != 3) begin
      if (m_k == 0 && v == 8'hA5) m_k = 1;
      else if (m_k == 1 && v == 8'hF1) m_k = 2;
      else m_k = 3;
    end
    chk(key_locked === (m_k == 3), "R7", key_locked, m_k == 3);
  endtask

  task automatic dbg_chk();
    bit open;
    open = (rd(SEC_ADDR) == 8'hFF);
    @(negedge clk) dbg_req = 1;
    @(negedge clk) dbg_req = 0;
    chk(dbg_grant === open && dbg_deny === !open, "R11", {dbg_grant, dbg_deny}, {open, !open});
    @(negedge clk);
    chk(!dbg_grant && !dbg_deny, "R11", {dbg_grant, dbg_deny}, 0);
  endtask

  // Flash stub update
  task automatic stub_apply(bit er, int a, logic [7:0] d);
    if (er) for (int i = 0; i < (1 << PW); i++) fmem[(a & ~((1 << PW) - 1)) + i] = 8'hFF;
    else fmem[a] = rd(a) & d;
    sec_byte = rd(SEC_ADDR);
  endtask

  task automatic wait_busy(bit er);
    int n = 0;
    while (busy && n < EC + 10) begin n++; @(negedge clk); end
    chk(n == (er ? EC : PC), "R9", n, er ? EC : PC);
    chk(done === 1'b1, "R9", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R9", done, 0);
  endtask

  task automatic store(logic [AW-1:0] a, logic [7:0] d);
    bit e_ram, e_prog, e_er;
    logic [AW-1:0] e_a;
    e_ram = 0; e_prog = 0; e_er = 0; e_a = a;
    if (!m_wr) e_ram = 1;
    else if (m_k == 2) begin
      m_k = 0;
      if (int'(a) < RES) begin
        if (m_er) begin e_er = 1; e_a = a & ~AW'((1 << PW) - 1); end
        else e_prog = 1;
      end
    end else m_k = 3;
    @(negedge clk) begin xd_we = 1; xd_addr = a; xd_wdata = d; end
    @(negedge clk) xd_we = 0;
    chk(ram_we === e_ram, "R3", ram_we, e_ram);
    if (e_ram) chk(ram_addr === a && ram_wdata === d, "R3", {ram_addr, ram_wdata}, {a, d});
    chk(fl_prog === e_prog, "R4", fl_prog, e_prog);
    chk(fl_erase === e_er, "R5", fl_erase, e_er);
    if (e_prog) chk(fl_addr === a && fl_wdata === d, "R4", {fl_addr, fl_wdata}, {a, d});
    if (e_er) chk(fl_addr === e_a, "R5", fl_addr, e_a);
    chk(key_locked === (m_k == 3), "R6", key_locked, m_k == 3);
    if (e_prog || e_er) begin
      stub_apply(e_er, int'(a), d);
      wait_busy(e_er);
    end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();                                   // R1
    // R3: RAM path
    store(13'h0123, 8'h5A);
    chk(!key_locked, "R3", key_locked, 0);
    // R2, R4: byte program
    ctrl_w(8'h01);
    key_w(8'hA5); key_w(8'hF1);
    store(13'h0040, 8'h3C);
    chk(rd('h40) == 8'h3C, "R4", rd('h40), 8'h3C);
    // R6: unlock consumed, second store locks
    store(13'h0041, 8'h11);
    do_reset();
    // R5: page erase
    ctrl_w(8'h03);
    key_w(8'hA5); key_w(8'hF1);
    store(13'h0077, 8'h00);
    chk(rd('h40) == 8'hFF, "R5", rd('h40), 8'hFF);
    // R8: reserved blocked, unlock consumed, not locked
    key_w(8'hA5); key_w(8'hF1);
    store(13'h1E00, 8'h00);
    chk(!key_locked, "R8", key_locked, 0);
    key_w(8'hA5); key_w(8'hF1);
    store(13'h1FFF, 8'h00);
    chk(!key_locked, "R8", key_locked, 0);
    store(13'h0100, 8'h00);                       // R8 unlock was spent -> lock
    // R7: out of order and dead until reset
    do_reset();
    key_w(8'hF1);
    key_w(8'hA5); key_w(8'hF1);
    ctrl_w(8'h01);
    store(13'h0200, 8'h00);
    do_reset();
    key_w(8'hA5); key_w(8'hF1); key_w(8'hA5);     // R7 key write while armed
    do_reset();
    // R11: program security byte, then reopen with erase
    dbg_chk();
    ctrl_w(8'h01);
    key_w(8'hA5); key_w(8'hF1);
    store(AW'(SEC_ADDR), 8'h00);
    dbg_chk();
    chk(sec_byte == 8'h00, "R11", sec_byte, 0);
    ctrl_w(8'h03);
    key_w(8'hA5); key_w(8'hF1);
    store(AW'(SEC_ADDR), 8'h00);
    dbg_chk();
    // R10: writes ignored while busy
    ctrl_w(8'h01);
    key_w(8'hA5); key_w(8'hF1);
    @(negedge clk) begin xd_we = 1; xd_addr = 13'h0300; xd_wdata = 8'h0F; end
    @(negedge clk) xd_we = 0;
    m_k = 0;
    stub_apply(0, 'h300, 8'h0F);
    chk(busy === 1 && fl_prog === 1, "R10", {busy, fl_prog}, 3);
    @(negedge clk) begin reg_we = 1; reg_sel = 0; reg_wdata = 8'h00; end
    @(negedge clk) begin reg_sel = 1; reg_wdata = 8'hA5; end
    @(negedge clk) begin reg_we = 0; xd_we = 1; xd_addr = 13'h0301; end
    @(negedge clk) xd_we = 0;
    chk(wr_en_bit === 1 && !ram_we && !fl_prog && !fl_erase && !key_locked, "R10",
        {wr_en_bit, ram_we, fl_prog, fl_erase, key_locked}, 5'b10000);
    wait (!busy);
    @(negedge clk);
    key_w(8'hF1);                                 // R10 A5 was dropped -> lock
    do_reset();
    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      if (m_k == 3 && ($urandom % 3) == 0) do_reset();
      else if (op < 2) ctrl_w(8'($urandom % 4));
      else if (op < 6) begin
        logic [7:0] v;
        v = 8'($urandom);
        if (($urandom % 10) != 0) v = (m_k == 1) ? 8'hF1 : 8'hA5;
        key_w(v);
      end else if (op < 9) begin
        logic [AW-1:0] a;
        a = AW'($urandom);
        if (($urandom % 8) != 0 && a >= AW'(RES)) a = a - AW'(RES);
        store(a, 8'($urandom));
      end else dbg_chk();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule